// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmit Master

This block sends parallel PCM words out over a three-wire serial audio link and generates the link's clocks itself. It divides its master clock into a bit clock. It drives a frame-sync line and a serial data line, and it supports four framings: standard I2S, left-justified, DSP short-sync (a one-bit pulse) and DSP long-sync (a pulse of programmable length). One shift path serves all four framings. The framings differ only in data offset, frame polarity, pulse width and slot count.

Upstream logic offers one word per slot on a valid/ready handshake. If no word is waiting when a slot starts, that slot is sent as zeros and a sticky underrun flag is set. All configuration inputs are sampled only at the first bit of a frame, so a single frame never mixes two settings. A reserved framing code, including the right-justified code, is refused at that moment: the previous framing stays in force and a sticky error flag is set.

Top module: `audio_ser_master`

## Requirements
- R1: `bclk` is low after reset. Each of its high and low phases lasts `cfg_div`+1 master clocks.
- R2: Words are sent MSB first. The slot width is 16 bits when `cfg_w24`=0 and 24 bits when it is 1. A 16-bit word is taken from `in_data[15:0]`. `sdata` and `fsync` change only on the master-clock edge that drives `bclk` low.
- R3: Mode 0 (I2S) has two slots. `fsync` is low for the left slot and high for the right slot. Each slot's MSB appears one bit clock after the `fsync` transition. The first bit after reset is 0.
- R4: Mode 1 (left-justified) has two slots. The MSB appears on the same bit clock as the `fsync` transition. `fsync` is low for the left slot, and `cfg_lj_inv`=1 inverts it.
- R5: Mode 2 (short sync) carries `cfg_slots`+1 slots (1 to 4). `fsync` is high for exactly the first bit of each frame, and that bit is the MSB of slot 0.
- R6: Mode 3 (long sync) carries `cfg_slots`+1 slots. `fsync` is high for the first `cfg_fs_len`+1 bits of the frame, and that count may exceed one slot.
- R7: Mode, word length, slot count, polarity, pulse length and divider are sampled only when a frame starts.
- R8: `in_ready` is high for exactly one master clock at the start of each slot. A word is accepted when `in_valid` is high in that cycle.
- R9: A slot that starts while `in_valid` is low is sent as zeros, and `underrun` rises and stays high until reset.
- R10: A mode code of 4 to 7 (4 is right-justified) found at a frame start is ignored. The previous framing continues, and `mode_err` rises and stays high until reset.
- R11: During reset, `bclk`, `fsync`, `sdata`, `in_ready`, `underrun` and `mode_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Framing: 0 I2S, 1 left-justified, 2 short sync, 3 long sync, 4-7 illegal |
| cfg_w24 | input | 1 | Word length: 0 is 16 bits, 1 is 24 bits |
| cfg_slots | input | 2 | Slots per frame minus one (DSP modes) |
| cfg_lj_inv | input | 1 | Invert frame sync in left-justified mode |
| cfg_fs_len | input | FSL_W | Long-sync pulse length minus one, in bit clocks |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in master clocks |
| in_valid | input | 1 | Upstream word available |
| in_data | input | 24 | Upstream PCM word |
| in_ready | output | 1 | Word taken this cycle (slot start) |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a slot started with no word |
| mode_err | output | 1 | Sticky: an illegal mode was refused |

## Verification
The assertions check the cycle-level rules on every cycle:
- `bclk` moves only when the divider count reaches its limit.
- `sdata` and `fsync` change only on the edge that drives `bclk` low.
- `in_ready` is only raised while `bclk` is high.
- The two flags stay high once set.
- The active mode is never an illegal code.

Whether the serialized bits and the sync pulses are correct depends on whole frames, so only the bench's scenarios can show it. The bench compares every cycle against a behavioural model while it varies the framing, word length, slot count, pulse length and divider, both at frame starts and in the middle of frames. It also withholds words to cause underruns and offers illegal mode codes.

// File: rtl/audio_ser_master.sv
module audio_ser_master #(
  parameter int DIV_W = 8,
  parameter int FSL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_w24,
  input  logic [1:0]       cfg_slots,
  input  logic             cfg_lj_inv,
  input  logic [FSL_W-1:0] cfg_fs_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             in_valid,
  input  logic [23:0]      in_data,
  output logic             in_ready,
  output logic             bclk,
  output logic             fsync,
  output logic             sdata,
  output logic             underrun,
  output logic             mode_err
);
  localparam logic [2:0] M_I2S = 3'd0, M_LJ = 3'd1, M_PS = 3'd2;

  logic [DIV_W-1:0] div_cnt, div_act;
  logic [2:0]       act_mode;
  logic             act_w24, act_inv, first, raw_prev, fs_n;
  logic [1:0]       act_slm1, slot_i;
  logic [FSL_W-1:0] act_fsl;
  logic [4:0]       bit_i;
  logic [23:0]      shreg;

  wire       tick      = div_cnt == div_act;
  wire       fall      = tick & bclk;
  wire [4:0] wl_m1     = act_w24 ? 5'd23 : 5'd15;
  wire [1:0] sl_m1     = (act_mode == M_I2S || act_mode == M_LJ) ? 2'd1 : act_slm1;
  wire       last_bit  = bit_i == wl_m1;
  wire       frm_start = first | (last_bit & (slot_i == sl_m1));
  wire       take      = frm_start & ~cfg_mode[2];

  wire [2:0]       eff_mode = take ? cfg_mode   : act_mode;
  wire             eff_w24  = take ? cfg_w24    : act_w24;
  wire             eff_inv  = take ? cfg_lj_inv : act_inv;
  wire [FSL_W-1:0] eff_fsl  = take ? cfg_fs_len : act_fsl;

  wire [4:0] nbit  = (frm_start | last_bit) ? 5'd0 : bit_i + 5'd1;
  wire [1:0] nslot = frm_start ? 2'd0 : (last_bit ? slot_i + 2'd1 : slot_i);
  wire [6:0] fbit  = 7'(nslot) * (eff_w24 ? 7'd24 : 7'd16) + 7'(nbit);

  assign in_ready = fall & (nbit == 5'd0);

  wire [23:0] word = !in_valid ? 24'd0 : (eff_w24 ? in_data : {in_data[15:0], 8'h00});
  wire [23:0] nsh  = in_ready ? word : {shreg[22:0], 1'b0};
  wire        raw  = nsh[23];

  always_comb begin
    case (eff_mode)
      M_I2S:   fs_n = nslot[0];
      M_LJ:    fs_n = nslot[0] ^ eff_inv;
      M_PS:    fs_n = fbit == 7'd0;
      default: fs_n = int'(fbit) <= int'(eff_fsl);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      div_act  <= '0;
      act_mode <= M_I2S;
      act_w24  <= 1'b0;
      act_slm1 <= 2'd1;
      act_inv  <= 1'b0;
      act_fsl  <= '0;
      first    <= 1'b1;
      bit_i    <= '0;
      slot_i   <= '0;
      shreg    <= '0;
      raw_prev <= 1'b0;
      bclk     <= 1'b0;
      fsync    <= 1'b0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) bclk <= ~bclk;
      if (fall) begin
        if (frm_start) begin
          first <= 1'b0;
          if (cfg_mode[2]) mode_err <= 1'b1;
          else begin
            act_mode <= cfg_mode;
            act_w24  <= cfg_w24;
            act_slm1 <= cfg_slots;
            act_inv  <= cfg_lj_inv;
            act_fsl  <= cfg_fs_len;
            div_act  <= cfg_div;
          end
        end
        bit_i    <= nbit;
        slot_i   <= nslot;
        shreg    <= nsh;
        raw_prev <= raw;
        sdata    <= (eff_mode == M_I2S) ? raw_prev : raw;
        fsync    <= fs_n;
        if (in_ready && !in_valid) underrun <= 1'b1;
      end
    end
  end
endmodule

module audio_ser_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk,
  input logic             sdata,
  input logic             fsync,
  input logic             in_ready,
  input logic             underrun,
  input logic             mode_err,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_act,
  input logic [2:0]       act_mode
);
  // R1
  bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != div_act) |=> $stable(bclk));
  // R2
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk) |-> $stable(sdata));
  // R2
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk) |-> $stable(fsync));
  // R8
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bclk);
  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);
  // R10
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode[2] == 1'b0);
endmodule

bind audio_ser_master audio_ser_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .sdata(sdata), .fsync(fsync),
  .in_ready(in_ready), .underrun(underrun), .mode_err(mode_err),
  .div_cnt(div_cnt), .div_act(div_act), .act_mode(act_mode)
);

// File: tb/tb_audio_ser_master.sv
module tb_audio_ser_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_w24 = 1'b0, cfg_lj_inv = 1'b0, in_valid = 1'b1;
  logic [1:0] cfg_slots = 2'd1;
  logic [6:0] cfg_fs_len = 7'd0;
  logic [7:0] cfg_div = 8'd0;
  logic [23:0] in_data = 24'd0;
  logic in_ready, bclk, fsync, sdata, underrun, mode_err;

  audio_ser_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_w24(cfg_w24),
    .cfg_slots(cfg_slots), .cfg_lj_inv(cfg_lj_inv), .cfg_fs_len(cfg_fs_len),
    .cfg_div(cfg_div), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .underrun(underrun), .mode_err(mode_err)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0, printed = 0;
  bit done = 0;

  int hc, bk, first, fb, mmode, mw, mns, minv, mfsl, mhp, acc;
  int prev, esd, efs, eur, eerr;
  logic [23:0] word;

  function automatic string mtag(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string what, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      if (printed < 20) begin
        printed++;
        $display("FAIL %s %s act=%0d exp=%0d t=%0t", what, tag, act, exp, $time);
      end
    end
  endtask

  task automatic do_fall();
    int k, raw, slot;
    if (first != 0 || fb == mw * mns - 1) begin
      first = 0;
      fb = 0;
      if (cfg_mode >= 4) eerr = 1;
      else begin
        mmode = cfg_mode;
        mw    = cfg_w24 ? 24 : 16;
        mns   = (mmode < 2) ? 2 : cfg_slots + 1;
        minv  = cfg_lj_inv;
        mfsl  = cfg_fs_len;
        mhp   = cfg_div + 1;
      end
    end else fb++;
    k = fb % mw;
    if (k == 0) begin
      if (in_valid) begin
        word = (mw == 24) ? in_data : {8'h00, in_data[15:0]};
        acc++;
      end else begin
        word = 0;
        eur = 1;
      end
    end
    raw = (word >> (mw - 1 - k)) & 1;
    esd = (mmode == 0) ? prev : raw;
    prev = raw;
    slot = fb / mw;
    case (mmode)
      0: efs = slot % 2;
      1: efs = (slot % 2) ^ minv;
      2: efs = (fb == 0) ? 1 : 0;
      default: efs = (fb <= mfsl) ? 1 : 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = 0; bk = 0; first = 1; fb = 0; mmode = 0; mw = 16; mns = 2; minv = 0;
      mfsl = 0; mhp = 1; prev = 0; esd = 0; efs = 0; eur = 0; eerr = 0; acc = 0; word = 0;
    end else if (hc == mhp - 1) begin
      hc = 0;
      if (bk == 0) bk = 1;
      else begin
        bk = 0;
        do_fall();
      end
    end else hc++;
  end

  always @(negedge clk) begin
    in_data <= 24'((acc * 32'h9E37B) ^ 32'h5A5A5);
    if (rst_n && !done) begin
      int er;
      er = (bk == 1 && hc == mhp - 1 &&
            (first != 0 || fb == mw * mns - 1 || fb % mw == mw - 1)) ? 1 : 0;
      check("bclk", "R1", bclk, bk);
      check("sdata R2 R7", mtag(mmode), sdata, esd);
      check("fsync R7", mtag(mmode), fsync, efs);
      check("in_ready", "R8", in_ready, er);
      check("underrun", "R9", underrun, eur);
      check("mode_err", "R10", mode_err, eerr);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("bclk rst", "R11", bclk, 0);
    check("fsync rst", "R11", fsync, 0);
    check("sdata rst", "R11", sdata, 0);
    check("ready rst", "R11", in_ready, 0);
    check("underrun rst", "R11", underrun, 0);
    check("mode_err rst", "R11", mode_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  initial begin
    do_reset();
    // R3 I2S 16-bit, fastest divider
    run(1500);
    // R3 I2S 24-bit, changed mid-frame (R7)
    cfg_w24 = 1; cfg_div = 2; run(3000);
    // R4 left-justified, normal then inverted polarity
    cfg_mode = 1; cfg_w24 = 0; cfg_div = 1; run(1500);
    cfg_lj_inv = 1; run(1500);
    // R5 short sync, one slot then four slots
    cfg_mode = 2; cfg_w24 = 1; cfg_slots = 0; cfg_div = 0; run(1000);
    cfg_slots = 3; run(1500);
    // R6 long sync, short pulse then pulse longer than a slot
    cfg_mode = 3; cfg_w24 = 0; cfg_slots = 2; cfg_fs_len = 3; run(1500);
    cfg_fs_len = 20; run(1500);
    // R9 underrun
    in_valid = 0; run(300);
    in_valid = 1; run(600);
    // R10 illegal codes, right-justified and another
    cfg_mode = 4; run(1000);
    cfg_mode = 7; run(500);
    cfg_mode = 2; cfg_slots = 1; run(800);
    do_reset();
    cfg_div = 3; run(1000);
    finish_up();
  end
endmodule